// File: doc/BRIEF.md
# Strobed Handshake Parallel Port

This block provides two byte-wide parallel ports for a microcontroller running in single-chip mode. The first is an output-only port. In simple mode, every CPU write to it emits a one-cycle pulse on the output strobe, so an external device can take the byte without polling. The second is a bidirectional port with a per-pin direction register. An edge on the input strobe captures its pin levels into a separate latched-data register and sets a status flag. The CPU clears the flag by reading the latched data.

A full handshake mode pairs the two strobe lines as request and acknowledge. The output strobe goes active when the CPU reads the latched data or writes new bidirectional data. It stays active until the next active input strobe edge. One control bit turns every pin of the bidirectional port into an open-drain driver for wired-OR buses. That bit takes effect only while the chip is in single-chip mode.

Top module: `hs_par_port`

## Requirements
- R1: After reset, all registers read zero, `pb_out`, `pc_oe` and `strb_out` are low, and the flag (control bit 7) is clear.
- R2: A write to address 1 appears on `pb_out` after that clock edge. A read of address 1 returns the written value.
- R3: A read of address 2 returns, for each bit, the data latch where the direction bit at address 3 is 1 (output), and the `pc_in` level where it is 0 (input).
- R4: With control bit 0 clear (simple mode), each write to address 1 makes the output strobe active for exactly the one cycle after the write edge. Writes to other addresses give no pulse.
- R5: Control bit 2 inverts the output strobe: 0 means active high, 1 means active low (idle high).
- R6: Control bit 1 picks the active input strobe edge (0 falling, 1 rising). On the active edge, `pc_in` is copied into the latched register (address 4) and the flag is set. The other edge changes neither.
- R7: A read of address 4 clears the flag.
- R8: With control bit 0 set (handshake mode), the output strobe goes active on a read of address 4 or a write of address 2. It stays active until the next active input strobe edge, which makes it inactive.
- R9: With control bit 3 set and `single_chip` high, an output pin holding 1 is not driven (`pc_oe` 0). An output pin holding 0 is driven low.
- R10: With `single_chip` low, control bit 3 has no effect and the pins are push-pull.
- R11: In push-pull operation, `pc_out` follows the data latch and `pc_oe` follows the direction register, one cycle after the register changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| single_chip | input | 1 | High when the chip runs in single-chip mode |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe |
| cpu_addr | input | 3 | Register address (0 control, 1 output port, 2 bidir data, 3 direction, 4 latched data) |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Registered read data |
| pb_out | output | 8 | Output-only port pins |
| strb_out | output | 1 | Output strobe |
| strb_in | input | 1 | Input strobe |
| pc_in | input | 8 | Bidirectional port pin levels |
| pc_out | output | 8 | Bidirectional port drive values |
| pc_oe | output | 8 | Bidirectional port drive enables |

## Verification
Register writes, read data, `pb_out` and the output strobe all change at the edge that takes the access. The bidirectional pin drive lags its registers by one more edge. An input strobe change passes two synchronizer stages, so the latch, the flag and the handshake release follow on the third edge after the pin moves. The bench drives every stimulus on a falling edge and counts falling edges to that due cycle before it samples. Where a lag is itself a requirement, it also samples once before the due cycle.

// File: rtl/hs_port_pkg.sv
package hs_port_pkg;

  typedef enum logic [2:0] {
    A_CTRL  = 3'd0,
    A_OUT   = 3'd1,
    A_DATA  = 3'd2,
    A_DIR   = 3'd3,
    A_LATCH = 3'd4
  } reg_addr_e;

  // control bits 3..0
  typedef struct packed {
    logic od;    // open-drain request
    logic inv;   // output strobe active low
    logic rise;  // input strobe active edge is rising
    logic hs;    // full handshake mode
  } ctrl_t;

  localparam int CTRL_BITS = 4;

endpackage

// File: rtl/hs_port_edge.sv
module hs_port_edge #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strb_in,
  input  logic rise_sel,
  output logic edge_hit
);
  logic [SYNC:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[SYNC-1:0], strb_in};
  end

  always_comb begin
    if (rise_sel) edge_hit = chain[SYNC-1] & ~chain[SYNC];
    else          edge_hit = ~chain[SYNC-1] & chain[SYNC];
  end
endmodule

// File: rtl/hs_port_strobe.sv
module hs_port_strobe (
  input  logic clk,
  input  logic rst,
  input  logic hs_mode,
  input  logic inv,
  input  logic wr_out_ev,
  input  logic wr_data_ev,
  input  logic rd_latch_ev,
  input  logic in_edge,
  output logic active,
  output logic strb_out
);
  logic act_d;

  always_comb begin
    if (hs_mode) begin
      if (rd_latch_ev || wr_data_ev) act_d = 1'b1;
      else if (in_edge)              act_d = 1'b0;
      else                           act_d = active;
    end else begin
      act_d = wr_out_ev;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) active <= 1'b0;
    else     active <= act_d;
  end

  assign strb_out = active ^ inv;
endmodule

// File: rtl/hs_port_pins.sv
module hs_port_pins #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] data,
  input  logic [W-1:0] dir,
  input  logic         od_en,
  output logic [W-1:0] pad_o,
  output logic [W-1:0] pad_oe
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst) begin
        pad_o[i]  <= 1'b0;
        pad_oe[i] <= 1'b0;
      end else begin
        pad_o[i]  <= data[i] & ~od_en;
        pad_oe[i] <= dir[i] & ~(od_en & data[i]);
      end
    end
  end
endmodule

// File: rtl/hs_par_port.sv
module hs_par_port #(
  parameter int W    = 8,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         single_chip,
  input  logic         cpu_wr,
  input  logic         cpu_rd,
  input  logic [2:0]   cpu_addr,
  input  logic [W-1:0] cpu_wdata,
  output logic [W-1:0] cpu_rdata,
  output logic [W-1:0] pb_out,
  output logic         strb_out,
  input  logic         strb_in,
  input  logic [W-1:0] pc_in,
  output logic [W-1:0] pc_out,
  output logic [W-1:0] pc_oe
);
  import hs_port_pkg::*;

  localparam int FLAG_BIT = W - 1;

  ctrl_t        ctrl_q;
  logic         flag_q;
  logic [W-1:0] out_q, data_q, dir_q, latch_q;
  logic         wr_ctrl, wr_out_ev, wr_data_ev, wr_dir, rd_latch_ev;
  logic         in_edge, stb_act, od_eff, hs_mode;
  logic [W-1:0] rd_mux;

  assign wr_ctrl     = cpu_wr && cpu_addr == A_CTRL;
  assign wr_out_ev   = cpu_wr && cpu_addr == A_OUT;
  assign wr_data_ev  = cpu_wr && cpu_addr == A_DATA;
  assign wr_dir      = cpu_wr && cpu_addr == A_DIR;
  assign rd_latch_ev = cpu_rd && cpu_addr == A_LATCH;
  assign od_eff      = ctrl_q.od & single_chip;
  assign hs_mode     = ctrl_q.hs;

  hs_port_edge #(.SYNC(SYNC)) edge_i (
    .clk(clk), .rst(rst), .strb_in(strb_in),
    .rise_sel(ctrl_q.rise), .edge_hit(in_edge)
  );

  hs_port_strobe strobe_i (
    .clk(clk), .rst(rst), .hs_mode(hs_mode), .inv(ctrl_q.inv),
    .wr_out_ev(wr_out_ev), .wr_data_ev(wr_data_ev),
    .rd_latch_ev(rd_latch_ev), .in_edge(in_edge),
    .active(stb_act), .strb_out(strb_out)
  );

  hs_port_pins #(.W(W)) pins_i (
    .clk(clk), .rst(rst), .data(data_q), .dir(dir_q), .od_en(od_eff),
    .pad_o(pc_out), .pad_oe(pc_oe)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      out_q  <= '0;
      data_q <= '0;
      dir_q  <= '0;
    end else begin
      if (wr_ctrl)    ctrl_q <= cpu_wdata[CTRL_BITS-1:0];
      if (wr_out_ev)  out_q  <= cpu_wdata;
      if (wr_data_ev) data_q <= cpu_wdata;
      if (wr_dir)     dir_q  <= cpu_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '0;
      flag_q  <= 1'b0;
    end else begin
      if (in_edge) latch_q <= pc_in;
      if (in_edge)          flag_q <= 1'b1;
      else if (rd_latch_ev) flag_q <= 1'b0;
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (cpu_addr)
      A_CTRL: begin
        rd_mux[CTRL_BITS-1:0] = ctrl_q;
        rd_mux[FLAG_BIT]      = flag_q;
      end
      A_OUT:   rd_mux = out_q;
      A_DATA:  rd_mux = (data_q & dir_q) | (pc_in & ~dir_q);
      A_DIR:   rd_mux = dir_q;
      A_LATCH: rd_mux = latch_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         cpu_rdata <= '0;
    else if (cpu_rd) cpu_rdata <= rd_mux;
  end

  assign pb_out = out_q;
endmodule

// File: rtl/hs_par_port_chk.sv
module hs_par_port_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         single_chip,
  input logic         hs_mode,
  input logic         wr_out_ev,
  input logic         in_edge,
  input logic         flag_q,
  input logic         stb_act,
  input logic         od_eff,
  input logic [W-1:0] pc_oe,
  input logic [W-1:0] pc_out,
  input logic [W-1:0] dir_q,
  input logic [W-1:0] pc_in,
  input logic [W-1:0] latch_q
);
  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    (!hs_mode && !wr_out_ev) |=> !stb_act);

  assert_latch_capture_R6: assert property (@(posedge clk) disable iff (rst)
    in_edge |=> (latch_q == $past(pc_in)));

  assert_flag_set_R7: assert property (@(posedge clk) disable iff (rst)
    in_edge |=> flag_q);

  assert_hs_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (hs_mode && stb_act && !in_edge) |=> stb_act);

  assert_od_no_high_R9: assert property (@(posedge clk) disable iff (rst)
    od_eff |=> ((pc_oe & pc_out) == '0));

  assert_pushpull_R10: assert property (@(posedge clk) disable iff (rst)
    !single_chip |=> (pc_oe == $past(dir_q)));
endmodule

bind hs_par_port hs_par_port_chk #(.W(W)) chk_i (
  .clk(clk), .rst(rst), .single_chip(single_chip), .hs_mode(hs_mode),
  .wr_out_ev(wr_out_ev), .in_edge(in_edge), .flag_q(flag_q),
  .stb_act(stb_act), .od_eff(od_eff), .pc_oe(pc_oe), .pc_out(pc_out),
  .dir_q(dir_q), .pc_in(pc_in), .latch_q(latch_q)
);

// File: tb/hs_par_port_tb.sv
module hs_par_port_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         single_chip = 1'b1;
  logic         cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [2:0]   cpu_addr = '0;
  logic [W-1:0] cpu_wdata = '0;
  logic [W-1:0] cpu_rdata, pb_out, pc_out, pc_oe;
  logic         strb_out;
  logic         strb_in = 1'b0;
  logic [W-1:0] pc_in = '0;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [W-1:0] m_out = '0, m_data = '0, m_dir = '0;
  logic         m_od = 0;

  always #2.5 clk = ~clk;

  hs_par_port #(.W(W)) dut_i (
    .clk, .rst, .single_chip, .cpu_wr, .cpu_rd, .cpu_addr, .cpu_wdata,
    .cpu_rdata, .pb_out, .strb_out, .strb_in, .pc_in, .pc_out, .pc_oe
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk);
    cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
    @(negedge clk);
    cpu_rd = 1'b1; cpu_addr = a;
    @(negedge clk);
    cpu_rd = 1'b0;
    d = cpu_rdata;
  endtask

  task automatic stb(input logic v);
    @(negedge clk);
    strb_in = v;
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [W-1:0] exp_oe(input logic [W-1:0] d, input logic [W-1:0] r, input logic od);
    return r & ~(od ? d : '0);
  endfunction

  function automatic logic [W-1:0] exp_o(input logic [W-1:0] d, input logic od);
    return od ? '0 : d;
  endfunction

  function automatic logic [W-1:0] exp_rd(input logic [W-1:0] d, input logic [W-1:0] r, input logic [W-1:0] p);
    return (d & r) | (p & ~r);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] v;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 pb_out", pb_out, 0);
    check("R1 pc_oe", pc_oe, 0);
    check("R1 strb_out", strb_out, 0);
    rd(3'd0, v); check("R1 ctrl", v, 0);
    rd(3'd4, v); check("R1 latch", v, 0);

    // R2 output port
    wr(3'd1, 8'hA5);
    check("R2 pb_out", pb_out, 8'hA5);
    check("R4 pulse active", strb_out, 1);
    @(negedge clk);
    check("R4 pulse ends", strb_out, 0);
    rd(3'd1, v); check("R2 readback", v, 8'hA5);
    m_out = 8'hA5;
    wr(3'd2, 8'h33);
    check("R4 no pulse on data write", strb_out, 0);

    // R11 one-cycle pin lag
    wr(3'd3, 8'hF0);
    check("R11 oe lags", pc_oe, 0);
    @(negedge clk);
    check("R11 oe", pc_oe, 8'hF0);
    check("R11 out", pc_out, 8'h33);
    m_data = 8'h33; m_dir = 8'hF0;

    // R3 mixed read
    pc_in = 8'h5C;
    rd(3'd2, v); check("R3 mixed read", v, 8'h3C);

    // R5 polarity
    wr(3'd0, 8'h04);
    check("R5 idle high", strb_out, 1);
    wr(3'd1, 8'h11);
    check("R5 active low", strb_out, 0);
    @(negedge clk);
    check("R5 back high", strb_out, 1);
    m_out = 8'h11;

    // R6 falling edge default, R7 flag
    wr(3'd0, 8'h00);
    pc_in = 8'h96;
    stb(1'b1);
    rd(3'd4, v); check("R6 rising ignored", v, 8'h00);
    rd(3'd0, v); check("R6 no flag on wrong edge", v, 8'h00);
    stb(1'b0);
    rd(3'd0, v); check("R7 flag set", v, 8'h80);
    rd(3'd4, v); check("R6 latched", v, 8'h96);
    rd(3'd0, v); check("R7 flag cleared", v, 8'h00);

    // R8 handshake, rising edge active
    wr(3'd0, 8'h03);
    wr(3'd2, 8'h44); m_data = 8'h44;
    check("R8 asserted on data write", strb_out, 1);
    repeat (5) @(negedge clk);
    check("R8 held", strb_out, 1);
    pc_in = 8'h21;
    stb(1'b1);
    check("R8 released on edge", strb_out, 0);
    rd(3'd4, v); check("R6 rising latched", v, 8'h21);
    check("R8 asserted on latch read", strb_out, 1);
    stb(1'b0);
    check("R8 falling ignored", strb_out, 1);
    stb(1'b1);
    check("R8 released again", strb_out, 0);
    stb(1'b0);
    wr(3'd0, 8'h00);

    // R9 / R10 directed
    wr(3'd2, 8'hF0); wr(3'd3, 8'hFF); m_data = 8'hF0; m_dir = 8'hFF;
    single_chip = 1'b0;
    wr(3'd0, 8'h08); m_od = 1;
    @(negedge clk);
    check("R10 od ignored oe", pc_oe, 8'hFF);
    check("R10 od ignored out", pc_out, 8'hF0);
    single_chip = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R9 ones released", pc_oe, 8'h0F);
    check("R9 zeros low", pc_out, 8'h00);

    // random mix
    for (int i = 0; i < 200; i++) begin
      int sel;
      logic [W-1:0] d;
      sel = $urandom_range(0, 3);
      d = W'($urandom);
      single_chip = 1'($urandom);
      pc_in = W'($urandom);
      case (sel)
        0: begin wr(3'd1, d); m_out = d; end
        1: begin wr(3'd2, d); m_data = d; end
        2: begin wr(3'd3, d); m_dir = d; end
        default: begin m_od = d[3]; wr(3'd0, {4'b0, m_od, 3'b0}); end
      endcase
      @(negedge clk);
      check("R2 random pb_out", pb_out, m_out);
      check("R9 random oe", pc_oe, exp_oe(m_data, m_dir, m_od & single_chip));
      check("R11 random out", pc_out, exp_o(m_data, m_od & single_chip));
      rd(3'd2, v); check("R3 random read", v, exp_rd(m_data, m_dir, pc_in));
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule